// File: doc/BRIEF.md
# Programmable Consecutive-Sample Input Glitch Filter

This block removes glitches from a set of asynchronous trigger and timing inputs. Each raw input first passes through a two-flop synchroniser. After that, on every enabled sample, the synchronised level is compared with the channel's current filtered output. A new level reaches the output only after it has been seen on a required number of consecutive samples. Any sample that agrees with the output clears the channel's count, so short bursts never add up across a glitch.

Each channel has its own 2-bit setting, and the channels are independent. There are three filter lengths and a bypass. The two shorter lengths sample on every clock, which is 40 MHz in normal use. The longest length samples only on a slow tick from a shared free-running prescaler, which is one clock in 400 by default. Bypass is what the block does when the settings input is held at zero after reset. In bypass the synchronised input is passed straight to the output. A change of setting clears that channel's count but leaves its output level as it is.

Top module: `glitch_filter`

## Requirements
- R1: While reset is held and on the first clock after its release, every filtered output is 0.
- R2: With setting 2'b00 (bypass), a channel's output equals its raw input as it stood three rising clock edges earlier.
- R3: With setting 2'b01, a new level must be sampled on SHORT_N (5) consecutive clocks to reach the output. A pulse lasting SHORT_N-1 clocks never appears.
- R4: With setting 2'b10, a new level must be sampled on MID_N (257) consecutive clocks to reach the output. A pulse lasting MID_N-1 clocks never appears.
- R5: With setting 2'b11, samples are taken only on the prescaler tick, which comes once every PRESCALE clocks. A new level must be seen on LONG_N (256) consecutive ticks to reach the output.
- R6: High-to-low transitions are filtered in exactly the same way as low-to-high transitions.
- R7: A sample equal to the current output clears the count. Interrupted pulses therefore never add together.
- R8: Each channel's setting and input affect only that channel's output.
- R9: Changing a channel's setting clears its count and does not change its output level on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_in | input | NCH | Asynchronous raw inputs, one bit per channel |
| mode | input | 2*NCH | Per-channel setting; channel c uses bits [2c+1:2c] |
| filt_out | output | NCH | Filtered outputs |

## Verification
In bypass, an input change is due at the output on the third rising edge after it is driven. That edge is spent as follows: two synchroniser stages, then the output register. In the counting modes, the output toggles on the edge where the N-th consecutive mismatching sample is taken. The synchroniser adds two edges in front of that. For the slowest mode, only edges that carry a prescaler tick are counted. The bench holds a behavioural model that steps once per rising edge, in the same order as the design, and compares every output at the falling edge that follows. Directed pulse tests record whether an output ever changed during a window that is long enough for any accepted pulse to show and then settle again.

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int NCH      = 4,
  parameter int SHORT_N  = 5,
  parameter int MID_N    = 257,
  parameter int LONG_N   = 256,
  parameter int PRESCALE = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   raw_in,
  input  logic [2*NCH-1:0] mode,
  output logic [NCH-1:0]   filt_out
);
  localparam int MAXN = (MID_N > LONG_N) ? ((MID_N > SHORT_N) ? MID_N : SHORT_N)
                                         : ((LONG_N > SHORT_N) ? LONG_N : SHORT_N);
  localparam int CW = $clog2(MAXN + 1);
  localparam int PW = $clog2(PRESCALE + 1);

  logic [PW-1:0]    pcnt;
  logic             tick;
  logic [NCH-1:0]   s1, s2;
  logic [2*NCH-1:0] mprev;

  assign tick = (pcnt == PW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt  <= '0;
      s1    <= '0;
      s2    <= '0;
      mprev <= '0;
    end else begin
      pcnt  <= tick ? '0 : pcnt + 1'b1;
      s1    <= raw_in;
      s2    <= s1;
      mprev <= mode;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [1:0]    m;
    logic [CW-1:0] thr, cnt;
    logic          en, q;

    assign m  = mode[2*g +: 2];
    assign en = (m == 2'b11) ? tick : 1'b1;
    assign filt_out[g] = q;

    always_comb begin
      case (m)
        2'b01:   thr = CW'(SHORT_N);
        2'b10:   thr = CW'(MID_N);
        default: thr = CW'(LONG_N);
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q   <= 1'b0;
        cnt <= '0;
      end else if (m == 2'b00) begin
        q   <= s2[g];
        cnt <= '0;
      end else if (m != mprev[2*g +: 2]) begin
        cnt <= '0;
      end else if (en) begin
        if (s2[g] == q) begin
          cnt <= '0;
        end else if (cnt == thr - 1'b1) begin
          q   <= ~q;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

module glitch_filter_chk #(
  parameter int NCH      = 4,
  parameter int PRESCALE = 400
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2*NCH-1:0] mode,
  input logic [2*NCH-1:0] mprev,
  input logic [NCH-1:0]   s2,
  input logic [NCH-1:0]   filt_out,
  input logic             tick
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    a_r2_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2*g +: 2] == 2'b00) |=> (filt_out[g] == $past(s2[g])));
    a_r7_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2*g +: 2] != 2'b00 && s2[g] == filt_out[g]) |=> $stable(filt_out[g]));
    a_r9_switch_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2*g +: 2] != 2'b00 && mode[2*g +: 2] != mprev[2*g +: 2]) |=> $stable(filt_out[g]));
  end
  if (PRESCALE > 1) begin : g_tick
    a_r5_tick_sparse: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> (filt_out == '0));
endmodule

bind glitch_filter glitch_filter_chk #(.NCH(NCH), .PRESCALE(PRESCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .mprev(mprev),
  .s2(s2), .filt_out(filt_out), .tick(tick)
);

// File: tb/tb_glitch_filter.sv
module tb_glitch_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int SN = 5, MN = 257, LN = 256, PS = 20;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] raw_in = '0;
  logic [2*NCH-1:0] mode = '0;
  logic [NCH-1:0] filt_out;
  int tests = 0, fails = 0;

  glitch_filter #(.NCH(NCH), .SHORT_N(SN), .MID_N(MN), .LONG_N(LN), .PRESCALE(PS)) dut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .mode(mode), .filt_out(filt_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  bit ms1[NCH], ms2[NCH], mq[NCH];
  int mcnt[NCH];
  int mpv[NCH];
  int tcnt;
  bit seen_hi[NCH], seen_lo[NCH];

  always @(posedge clk) begin
    if (!rst_n) begin
      tcnt = 0;
      foreach (mq[c]) begin ms1[c] = 0; ms2[c] = 0; mq[c] = 0; mcnt[c] = 0; mpv[c] = 0; end
    end else begin
      bit tk;
      tk = (tcnt == PS - 1);
      tcnt = tk ? 0 : tcnt + 1;
      foreach (mq[c]) begin
        int md, need;
        md = int'(mode[2*c +: 2]);
        need = (md == 1) ? SN : (md == 2) ? MN : LN;
        if (md == 0) begin mq[c] = ms2[c]; mcnt[c] = 0; end
        else if (md != mpv[c]) mcnt[c] = 0;
        else if (md != 3 || tk) begin
          if (ms2[c] == mq[c]) mcnt[c] = 0;
          else begin
            mcnt[c]++;
            if (mcnt[c] == need) begin mq[c] = !mq[c]; mcnt[c] = 0; end
          end
        end
        mpv[c] = md;
        ms2[c] = ms1[c];
        ms1[c] = raw_in[c];
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    foreach (mq[c]) begin
      chk("R2-R9 model", int'(filt_out[c]), int'(mq[c]));
      if (filt_out[c]) seen_hi[c] = 1; else seen_lo[c] = 1;
    end
  end

  task automatic clr_seen();
    foreach (seen_hi[c]) begin seen_hi[c] = 0; seen_lo[c] = 0; end
  endtask

  task automatic setm(int c, logic [1:0] v);
    mode[2*c +: 2] = v;
  endtask

  task automatic pulse(int c, bit lvl, int w, int settle);
    raw_in[c] = lvl;
    repeat (w) @(negedge clk);
    raw_in[c] = !lvl;
    repeat (settle) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out", int'(filt_out), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", int'(filt_out), 0);

    // R2 bypass latency on channel 2
    raw_in[2] = 1;
    repeat (2) @(negedge clk);
    chk("R2 not yet", int'(filt_out[2]), 0);
    @(negedge clk);
    chk("R2 third edge", int'(filt_out[2]), 1);
    raw_in[2] = 0;
    repeat (4) @(negedge clk);

    // R3 short setting on channel 0
    setm(0, 2'b01);
    repeat (3) @(negedge clk);
    clr_seen();
    pulse(0, 1, SN - 1, 12);
    chk("R3 short pulse rejected", int'(seen_hi[0]), 0);
    clr_seen();
    pulse(0, 1, SN, 12);
    chk("R3 pulse passes", int'(seen_hi[0]), 1);
    chk("R3 back low", int'(filt_out[0]), 0);

    // R7 interrupted pulse
    clr_seen();
    raw_in[0] = 1; repeat (3) @(negedge clk);
    raw_in[0] = 0; @(negedge clk);
    pulse(0, 1, 3, 12);
    chk("R7 split pulse rejected", int'(seen_hi[0]), 0);

    // R6 falling transitions
    raw_in[0] = 1; repeat (12) @(negedge clk);
    chk("R6 steady high", int'(filt_out[0]), 1);
    clr_seen();
    pulse(0, 0, SN - 1, 12);
    chk("R6 short low rejected", int'(seen_lo[0]), 0);
    clr_seen();
    pulse(0, 0, SN, 12);
    chk("R6 low pulse passes", int'(seen_lo[0]), 1);
    raw_in[0] = 0; repeat (12) @(negedge clk);

    // R8 independence: ch0 short, ch3 mid, ch2 bypass, same stimulus
    setm(3, 2'b10); setm(2, 2'b00);
    repeat (3) @(negedge clk);
    clr_seen();
    raw_in[0] = 1; raw_in[2] = 1; raw_in[3] = 1;
    repeat (10) @(negedge clk);
    raw_in[0] = 0; raw_in[2] = 0; raw_in[3] = 0;
    repeat (12) @(negedge clk);
    chk("R8 ch0 passes", int'(seen_hi[0]), 1);
    chk("R8 ch2 passes", int'(seen_hi[2]), 1);
    chk("R8 ch3 rejects", int'(seen_hi[3]), 0);
    chk("R8 ch1 untouched", int'(seen_hi[1]), 0);

    // R4 mid setting on channel 3
    clr_seen();
    pulse(3, 1, MN - 1, 300);
    chk("R4 pulse rejected", int'(seen_hi[3]), 0);
    clr_seen();
    pulse(3, 1, MN, 300);
    chk("R4 pulse passes", int'(seen_hi[3]), 1);
    chk("R4 back low", int'(filt_out[3]), 0);

    // R9 setting change clears count, keeps level
    setm(1, 2'b01);
    repeat (3) @(negedge clk);
    clr_seen();
    raw_in[1] = 1;
    repeat (5) @(negedge clk);
    setm(1, 2'b10);
    repeat (10) @(negedge clk);
    chk("R9 count cleared", int'(seen_hi[1]), 0);
    setm(1, 2'b01);
    repeat (10) @(negedge clk);
    chk("R9 short again passes", int'(filt_out[1]), 1);
    raw_in[1] = 0;
    repeat (3) @(negedge clk);
    setm(1, 2'b10);
    repeat (20) @(negedge clk);
    chk("R9 level kept", int'(filt_out[1]), 1);
    setm(1, 2'b00);
    repeat (2) @(negedge clk);
    chk("R2 bypass resumes", int'(filt_out[1]), 0);

    // R5 long setting on channel 1
    setm(1, 2'b11);
    repeat (3) @(negedge clk);
    clr_seen();
    pulse(1, 1, (LN - 2) * PS, (LN + 2) * PS);
    chk("R5 pulse rejected", int'(seen_hi[1]), 0);
    clr_seen();
    pulse(1, 1, (LN + 1) * PS, (LN + 2) * PS);
    chk("R5 pulse passes", int'(seen_hi[1]), 1);
    chk("R5 back low", int'(filt_out[1]), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule